// File: doc/BRIEF.md
# Periodic Time and Calendar Event Unit

This unit sits beside a time/date counter and turns its single-cycle tick and rollover pulses into sticky event flags. Two of the flags come from selectable sources. The time event follows a minute, hour, midnight or noon pulse, and the calendar event follows a week, month or year pulse. The other four flags come directly from the second tick, the alarm match, the update acknowledge and the free-running error inputs.

Software reads the flags through a small word-addressed register bus. It clears a flag by writing a one to its bit in a clear command register. It sets interrupt mask bits through an enable register and clears them through a separate disable register. A single registered interrupt line is high while any flag is both set and unmasked. The counting of time itself is done elsewhere.

Top module: `tcev_unit`

## Requirements
- R1: After reset every flag, every mask bit and both selectors are zero, `irq` is low, and every readable address returns zero.
- R2: The time event flag (bit 3) is set by exactly one pulse input, chosen by the time selector: code 0 selects the minute pulse, 1 the hour pulse, 2 midnight, 3 noon. Pulses on the unselected inputs leave it unchanged.
- R3: The calendar event flag (bit 4) is set by the pulse chosen by the calendar selector: code 0 selects the week pulse, 1 the month pulse, 2 the year pulse. Code 3 selects nothing, and no calendar pulse sets the flag.
- R4: The remaining flags map one-to-one to their inputs: bit 0 update acknowledge, bit 1 alarm match, bit 2 second tick, bit 5 free-running error. A flag is set at the clock edge that samples its pulse, and it stays set.
- R5: A write to the clear register clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: When a pulse sets a flag in the same cycle that a clear command targets it, the flag ends up set. Other flags cleared by the same command still clear.
- R7: Writing 1s to the enable register sets the matching mask bits. Writing 1s to the disable register clears them. Zero bits leave the mask unchanged, and the mask reads back at address 5 using the flag bit order.
- R8: `irq` is the OR over all six bits of flag AND mask. It is taken from a register, so it follows a change of flags or mask by exactly one clock cycle.
- R9: Address map: 0 control (time selector in data bits 1:0, calendar selector in bits 5:4, read/write), 1 flags (read-only), 2 clear, 3 enable, 4 disable, 5 mask (read-only). The clear, enable and disable registers, and addresses 6 and 7, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| p_second | input | 1 | Second tick pulse |
| p_minute | input | 1 | Minute rollover pulse |
| p_hour | input | 1 | Hour rollover pulse |
| p_midnight | input | 1 | Midnight pulse |
| p_noon | input | 1 | Noon pulse |
| p_week | input | 1 | Week start pulse |
| p_month | input | 1 | Month start pulse |
| p_year | input | 1 | Year start pulse |
| p_alarm | input | 1 | Alarm match pulse |
| p_upd_ack | input | 1 | Update acknowledge pulse |
| p_run_err | input | 1 | Free-running error pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong selector decode sets the flag register from the wrong pulse input. The flag reads back wrong on the first read after that pulse edge. A flag that fails to set, or a clear that wins against a set, shows up on the same read. A bad mask update shows at address 5 in the cycle after the write. A wrong interrupt combine or pipeline depth shows at `irq` exactly one edge after the flag or mask changes, so the bench samples `irq` both before and after that edge.

// File: rtl/tcev_pkg.sv
package tcev_pkg;

    localparam int unsigned NFLAG = 6;

    // flag bit positions (software decodes these)
    localparam int unsigned FLG_ACK   = 0;
    localparam int unsigned FLG_ALARM = 1;
    localparam int unsigned FLG_SEC   = 2;
    localparam int unsigned FLG_TIME  = 3;
    localparam int unsigned FLG_CAL   = 4;
    localparam int unsigned FLG_ERR   = 5;

    // control register field positions
    localparam int unsigned TSEL_LSB = 0;
    localparam int unsigned CSEL_LSB = 4;
    localparam int unsigned CTRL_W   = CSEL_LSB + 2;

    typedef logic [NFLAG-1:0] flag_t;

    typedef enum logic [1:0] {
        TSEL_MINUTE   = 2'd0,
        TSEL_HOUR     = 2'd1,
        TSEL_MIDNIGHT = 2'd2,
        TSEL_NOON     = 2'd3
    } tsel_e;

    typedef enum logic [1:0] {
        CSEL_WEEK  = 2'd0,
        CSEL_MONTH = 2'd1,
        CSEL_YEAR  = 2'd2,
        CSEL_NONE  = 2'd3
    } csel_e;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_STATUS  = 3'd1,
        RA_CLEAR   = 3'd2,
        RA_ENABLE  = 3'd3,
        RA_DISABLE = 3'd4,
        RA_MASK    = 3'd5
    } raddr_e;

    typedef struct packed {
        tsel_e tsel;
        csel_e csel;
    } ctrl_t;

    typedef struct packed {
        logic sec;
        logic minute;
        logic hour;
        logic midnight;
        logic noon;
        logic week;
        logic month;
        logic year;
        logic alarm;
        logic upd_ack;
        logic run_err;
    } pulse_t;

    // assemble the per-cycle set vector in flag bit order
    function automatic flag_t gather_set(input pulse_t p, input logic tev, input logic cev);
        flag_t v;
        v            = '0;
        v[FLG_ACK]   = p.upd_ack;
        v[FLG_ALARM] = p.alarm;
        v[FLG_SEC]   = p.sec;
        v[FLG_TIME]  = tev;
        v[FLG_CAL]   = cev;
        v[FLG_ERR]   = p.run_err;
        return v;
    endfunction

    // pack control fields into register layout
    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] r;
        r                         = '0;
        r[TSEL_LSB +: 2]          = c.tsel;
        r[CSEL_LSB +: 2]          = c.csel;
        return r;
    endfunction

endpackage

// File: rtl/tcev_ctrl_reg.sv
module tcev_ctrl_reg
    import tcev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_bits,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.tsel <= TSEL_MINUTE;
            ctrl.csel <= CSEL_WEEK;
        end else if (wr_en) begin
            ctrl.tsel <= tsel_e'(wr_bits[TSEL_LSB +: 2]);
            ctrl.csel <= csel_e'(wr_bits[CSEL_LSB +: 2]);
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl)) else $error("control changed without write"); // R9

endmodule

// File: rtl/tcev_event_sel.sv
module tcev_event_sel
    import tcev_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctrl_t  ctrl,
    input  pulse_t pulses,
    output logic   time_evt,
    output logic   cal_evt
);

    always_comb begin
        unique case (ctrl.tsel)
            TSEL_MINUTE:   time_evt = pulses.minute;
            TSEL_HOUR:     time_evt = pulses.hour;
            TSEL_MIDNIGHT: time_evt = pulses.midnight;
            TSEL_NOON:     time_evt = pulses.noon;
            default:       time_evt = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ctrl.csel)
            CSEL_WEEK:  cal_evt = pulses.week;
            CSEL_MONTH: cal_evt = pulses.month;
            CSEL_YEAR:  cal_evt = pulses.year;
            default:    cal_evt = 1'b0;
        endcase
    end

    AST_CAL_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.csel == CSEL_NONE) |-> !cal_evt) else $error("reserved calendar code fired"); // R3

    AST_TIME_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        time_evt |-> (pulses.minute || pulses.hour || pulses.midnight || pulses.noon))
        else $error("time event without any time pulse"); // R2

    AST_CAL_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        cal_evt |-> (pulses.week || pulses.month || pulses.year))
        else $error("calendar event without any calendar pulse"); // R3

endmodule

// File: rtl/tcev_status.sv
module tcev_status
    import tcev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  flag_t set_vec,
    input  logic  clr_wr,
    input  flag_t clr_bits,
    output flag_t flags
);

    flag_t clr_eff;
    flag_t flags_nxt;

    assign clr_eff = clr_wr ? clr_bits : '0;

    // set has priority over clear per bit
    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_bit
            always_comb begin
                if (set_vec[i])
                    flags_nxt[i] = 1'b1;
                else if (clr_eff[i])
                    flags_nxt[i] = 1'b0;
                else
                    flags_nxt[i] = flags[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= flags_nxt;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)))
        else $error("pulse did not set its flag"); // R6

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((flags & $past(clr_bits & ~set_vec)) == '0))
        else $error("clear command left flag set"); // R5

    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && set_vec == '0) |=>
            ((flags & ~$past(clr_bits)) == ($past(flags) & ~$past(clr_bits))))
        else $error("clear with zero bit changed flag"); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && set_vec == '0) |=> $stable(flags))
        else $error("flag changed with no set or clear"); // R4

endmodule

// File: rtl/tcev_irq_ctrl.sv
module tcev_irq_ctrl
    import tcev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_wr,
    input  logic  dis_wr,
    input  flag_t wr_bits,
    input  flag_t flags,
    output flag_t mask,
    output logic  irq
);

    flag_t en_bits;
    flag_t dis_bits;

    assign en_bits  = en_wr  ? wr_bits : '0;
    assign dis_bits = dis_wr ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            mask <= (mask | en_bits) & ~dis_bits;
            irq  <= |(flags & mask);
        end
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> ((mask & $past(wr_bits)) == $past(wr_bits)))
        else $error("enable did not set mask"); // R7

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        dis_wr |=> ((mask & $past(wr_bits)) == '0))
        else $error("disable did not clear mask"); // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_wr && !dis_wr) |=> $stable(mask))
        else $error("mask changed without write"); // R7

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        ((flags & mask) != '0) |=> irq) else $error("irq missed"); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((flags & mask) == '0) |=> !irq) else $error("spurious irq"); // R8

endmodule

// File: rtl/tcev_unit.sv
module tcev_unit
    import tcev_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              p_second,
    input  logic              p_minute,
    input  logic              p_hour,
    input  logic              p_midnight,
    input  logic              p_noon,
    input  logic              p_week,
    input  logic              p_month,
    input  logic              p_year,
    input  logic              p_alarm,
    input  logic              p_upd_ack,
    input  logic              p_run_err,
    output logic              irq
);

    localparam int unsigned LOW_W = (CTRL_W > NFLAG) ? CTRL_W : NFLAG;

    pulse_t pulses;
    ctrl_t  ctrl;
    flag_t  flags;
    flag_t  mask;
    flag_t  set_vec;
    logic   time_evt;
    logic   cal_evt;
    logic   wr_ctrl, wr_clear, wr_enable, wr_disable;

    wire unused_wdata = ^{1'b0, bus_wdata[DATA_W-1:LOW_W], bus_wdata[CSEL_LSB-1:TSEL_LSB+2]};

    assign pulses = '{sec: p_second, minute: p_minute, hour: p_hour,
                      midnight: p_midnight, noon: p_noon, week: p_week,
                      month: p_month, year: p_year, alarm: p_alarm,
                      upd_ack: p_upd_ack, run_err: p_run_err};

    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
    assign wr_clear   = bus_wr && (bus_addr == ADDR_W'(RA_CLEAR));
    assign wr_enable  = bus_wr && (bus_addr == ADDR_W'(RA_ENABLE));
    assign wr_disable = bus_wr && (bus_addr == ADDR_W'(RA_DISABLE));

    tcev_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ctrl),
        .wr_bits (bus_wdata[CTRL_W-1:0]),
        .ctrl    (ctrl)
    );

    tcev_event_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .pulses   (pulses),
        .time_evt (time_evt),
        .cal_evt  (cal_evt)
    );

    assign set_vec = gather_set(pulses, time_evt, cal_evt);

    tcev_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (wr_clear),
        .clr_bits (bus_wdata[NFLAG-1:0]),
        .flags    (flags)
    );

    tcev_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (wr_enable),
        .dis_wr  (wr_disable),
        .wr_bits (bus_wdata[NFLAG-1:0]),
        .flags   (flags),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(RA_CTRL))
            bus_rdata = DATA_W'(ctrl_pack(ctrl));
        else if (bus_addr == ADDR_W'(RA_STATUS))
            bus_rdata = DATA_W'(flags);
        else if (bus_addr == ADDR_W'(RA_MASK))
            bus_rdata = DATA_W'(mask);
    end

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(RA_CLEAR) || bus_addr == ADDR_W'(RA_ENABLE) ||
         bus_addr == ADDR_W'(RA_DISABLE)) |-> (bus_rdata == '0))
        else $error("write-only register read nonzero"); // R9

endmodule

// File: tb/tcev_unit_test.sv
module tcev_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] pv = '0;   // 0 sec,1 min,2 hour,3 midnight,4 noon,5 week,6 month,7 year,8 alarm,9 ack,10 err
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tcev_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .p_second(pv[0]), .p_minute(pv[1]), .p_hour(pv[2]), .p_midnight(pv[3]),
        .p_noon(pv[4]), .p_week(pv[5]), .p_month(pv[6]), .p_year(pv[7]),
        .p_alarm(pv[8]), .p_upd_ack(pv[9]), .p_run_err(pv[10]), .irq(irq)
    );

    // {tsel[1:0], csel[1:0], src[3:0], expected flags[5:0]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 2'd0, 4'd1,  6'h08},
        {2'd0, 2'd0, 4'd2,  6'h00},
        {2'd1, 2'd0, 4'd2,  6'h08},
        {2'd1, 2'd0, 4'd1,  6'h00},
        {2'd2, 2'd0, 4'd3,  6'h08},
        {2'd2, 2'd0, 4'd4,  6'h00},
        {2'd3, 2'd0, 4'd4,  6'h08},
        {2'd3, 2'd0, 4'd3,  6'h00},
        {2'd0, 2'd0, 4'd5,  6'h10},
        {2'd0, 2'd1, 4'd6,  6'h10},
        {2'd0, 2'd1, 4'd5,  6'h00},
        {2'd0, 2'd2, 4'd7,  6'h10},
        {2'd0, 2'd3, 4'd7,  6'h00},
        {2'd0, 2'd3, 4'd5,  6'h00},
        {2'd0, 2'd0, 4'd0,  6'h04},
        {2'd0, 2'd0, 4'd8,  6'h02},
        {2'd0, 2'd0, 4'd9,  6'h01},
        {2'd0, 2'd0, 4'd10, 6'h20}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        pv = 11'(1) << idx;
        @(negedge clk);
        pv = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            check("R1 reset readback", rd, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R9: control readback layout
        bus_write(3'd0, 32'h0000_0023);
        bus_read(3'd0, rd);
        check("R9 control readback", rd, 32'h0000_0023);

        // table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            bus_write(3'd2, 32'h3F);
            bus_write(3'd0, {26'b0, VEC[i][11:10], 2'b00, VEC[i][13:12]});
            pulse(int'(VEC[i][9:6]));
            bus_read(3'd1, rd);
            check($sformatf("R2/R3/R4 vector %0d", i), rd, {26'b0, VEC[i][5:0]});
        end

        // R4 sticky over idle cycles
        bus_write(3'd2, 32'h3F);
        pulse(0);
        repeat (4) @(negedge clk);
        bus_read(3'd1, rd);
        check("R4 flag stays set", rd, 32'h04);

        // R5: zero bits have no effect, one bits clear
        pulse(8);
        bus_write(3'd2, 32'h00);
        bus_read(3'd1, rd);
        check("R5 clear with zeros", rd, 32'h06);
        bus_write(3'd2, 32'h04);
        bus_read(3'd1, rd);
        check("R5 clear selected bit", rd, 32'h02);

        // R6: set wins over clear same cycle
        pulse(0);                       // flags now 0x06
        @(negedge clk);
        bus_addr = 3'd2; bus_wr = 1'b1; bus_wdata = 32'h06; pv = 11'(1) << 8;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; pv = '0;
        bus_read(3'd1, rd);
        check("R6 set beats clear", rd, 32'h02);

        // R9: write-only registers and unused addresses read zero
        bus_write(3'd3, 32'h3F);
        bus_write(3'd4, 32'h3C);
        for (int a = 2; a < 5; a++) begin
            bus_read(3'(a), rd);
            check("R9 write-only reads zero", rd, 32'h0);
        end
        bus_read(3'd6, rd);
        check("R9 unused address", rd, 32'h0);

        // R7: mask set / clear / zero no effect
        bus_read(3'd5, rd);
        check("R7 mask after enable/disable", rd, 32'h03);
        bus_write(3'd3, 32'h00);
        bus_write(3'd4, 32'h00);
        bus_read(3'd5, rd);
        check("R7 zero writes keep mask", rd, 32'h03);

        // R8: irq timing
        do_reset();
        bus_write(3'd3, 32'h02);
        check("R8 irq idle", {31'b0, irq}, 32'h0);
        pulse(0);                        // second flag, unmasked
        @(negedge clk);
        check("R8 masked flag no irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        pv = 11'(1) << 8;
        @(negedge clk);
        pv = '0;
        check("R8 irq one cycle late", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq rises", {31'b0, irq}, 32'h1);
        bus_write(3'd2, 32'h02);
        check("R8 irq lags clear", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
        pulse(8);
        @(negedge clk);
        check("R8 irq again", {31'b0, irq}, 32'h1);
        bus_write(3'd4, 32'h02);
        @(negedge clk);
        check("R8 irq drops after disable", {31'b0, irq}, 32'h0);
        bus_write(3'd3, 32'h04);
        @(negedge clk);
        check("R8 irq from enabled second flag", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule